// File: doc/BRIEF.md
# Level-Sensitive Banked Interrupt Controller

This controller gathers two banks of level-sensitive interrupt requests: a peripheral bank of 64 lines and a local bank of 8 lines. It masks each line with its own enable bit. It drives a combined normal interrupt output and a single fast interrupt output. The fast output follows one source that software selects from either bank. Input levels are never latched. Every pending view is the live input level ANDed with its enable bit.

Software reaches the block through a plain synchronous register port: a read strobe, a write strobe, a byte address and 32-bit data. Enable masks are changed through paired set and clear registers, so one line can be enabled or disabled without a read-modify-write. A summary register combines several views in one word: the local bank, an "any pending" flag for each peripheral half, and mirrored copies of eleven chosen peripheral lines. An interrupt handler can often decide what to do from this one read.

Top module: `banked_irq_ctrl`

## Requirements
- R1: After reset, every enable mask and the fast enable read as zero, and both interrupt outputs are low.
- R2: Offset 0x04 reads (peripheral lines 31:0 AND enable) and offset 0x08 reads (peripheral lines 63:32 AND enable), from the live input levels.
- R3: Summary register, offset 0x00: bits 7:0 hold the enabled pending local lines. Bit 8 is set when any enabled line 0–31 is pending, and bit 9 when any enabled line 32–63 is pending. Bits 31:21 read zero.
- R4: Summary bits 10 to 20 mirror the enabled pending state of peripheral lines 7, 9, 10, 18, 19, 53, 54, 55, 56, 57 and 62, in that order.
- R5: A write to a set register ORs the written ones into its mask, and a read of that register returns the mask. The set registers are 0x10 (lines 31:0), 0x14 (lines 63:32) and 0x18 (local lines). Only bits 7:0 act at 0x18, and that register reads zero above bit 7.
- R6: A write to a clear register clears the mask bits where ones are written. A read of a clear register returns the inverted mask. The clear registers are 0x1C, 0x20 and 0x24, in the same order as the set registers. At 0x24 only bits 7:0 act, and the inverted local mask reads with zeros above bit 7.
- R7: Offset 0x0C holds the fast selector in bits 6:0 and the fast enable in bit 7. It reads back in the same layout, with zeros above bit 7.
- R8: The fast output follows the raw level of the selected source and ignores the enable masks. Selector values 0–63 pick a peripheral line and 64–71 pick local line (selector − 64). A value of 72 or more, or a cleared fast enable, keeps the output low.
- R9: The normal interrupt output is high exactly when some enabled line in either bank is pending.
- R10: Reads of unmapped offsets return zero. Writes to unmapped offsets or to the pending registers change no state.
- R11: Both outputs are registered and show an input or enable change one clock later. Read data appears one clock after the read strobe and holds while no read is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| per_lines | input | 64 | Peripheral interrupt levels |
| loc_lines | input | 8 | Local interrupt levels |
| irq_out | output | 1 | Combined normal interrupt |
| fiq_out | output | 1 | Selected fast interrupt |

## Verification
The bench builds the block with its default sizes: 64 peripheral lines, 8 local lines, a 7-bit selector and an 8-bit address. With these sizes the full register map is reachable, including both peripheral halves. The selector can also reach the gap above the last local line (values 72 to 127). Sweeping one active line through each mirrored position separates the mirror order from the per-half flags.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 8;
    localparam int PER_N    = 64;
    localparam int HALF_N   = PER_N / 2;
    localparam int LOC_N    = 8;
    localparam int SEL_W    = 7;
    localparam int MIRROR_N = 11;
    localparam int SUM_PAD  = DATA_W - MIRROR_N - 2 - LOC_N;

    typedef enum logic [ADDR_W-1:0] {
        OFF_SUMMARY = 8'h00,
        OFF_PEND_LO = 8'h04,
        OFF_PEND_HI = 8'h08,
        OFF_FAST    = 8'h0C,
        OFF_SET_LO  = 8'h10,
        OFF_SET_HI  = 8'h14,
        OFF_SET_LOC = 8'h18,
        OFF_CLR_LO  = 8'h1C,
        OFF_CLR_HI  = 8'h20,
        OFF_CLR_LOC = 8'h24
    } reg_off_e;

    typedef struct packed {
        logic             en;
        logic [SEL_W-1:0] sel;
    } fast_cfg_t;

    typedef struct packed {
        logic [1:0] set_per;
        logic [1:0] clr_per;
        logic       set_loc;
        logic       clr_loc;
        logic       fast;
    } wr_dec_t;

    // Peripheral line copied into summary bit (10 + idx)
    function automatic int mirror_line(input int idx);
        case (idx)
            0:       return 7;
            1:       return 9;
            2:       return 10;
            3:       return 18;
            4:       return 19;
            5:       return 53;
            6:       return 54;
            7:       return 55;
            8:       return 56;
            9:       return 57;
            default: return 62;
        endcase
    endfunction
endpackage

// File: rtl/irqc_en_bank.sv
module irqc_en_bank #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_we,
    input  logic             clr_we,
    input  logic [WIDTH-1:0] bits,
    output logic [WIDTH-1:0] mask
);
    always_ff @(posedge clk) begin
        if (rst)
            mask <= '0;
        else if (set_we)
            mask <= mask | bits;
        else if (clr_we)
            mask <= mask & ~bits;
    end

    // R5
    set_keeps_bits_chk: assert property (@(posedge clk) disable iff (rst)
        set_we |=> ((mask & $past(bits)) == $past(bits)));
    // R6
    clr_drops_bits_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_we && !set_we) |=> ((mask & $past(bits)) == '0));
    // R10
    idle_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_we && !clr_we) |=> $stable(mask));
endmodule

// File: rtl/irqc_fast_pick.sv
module irqc_fast_pick
    import irqc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_wdata,
    input  logic [PER_N-1:0] per_lines,
    input  logic [LOC_N-1:0] loc_lines,
    output fast_cfg_t        cfg,
    output logic             fiq
);
    localparam int LOC_IDX_W = $clog2(LOC_N);

    logic [SEL_W-1:0] loc_idx;
    logic             loc_hit;
    logic             raw;

    always_ff @(posedge clk) begin
        if (rst)
            cfg <= '0;
        else if (cfg_we)
            cfg <= fast_cfg_t'(cfg_wdata);
    end

    always_comb begin
        loc_idx = cfg.sel - SEL_W'(PER_N);
        loc_hit = (cfg.sel >= SEL_W'(PER_N)) && (loc_idx < SEL_W'(LOC_N));
        if (cfg.sel < SEL_W'(PER_N))
            raw = per_lines[cfg.sel[$clog2(PER_N)-1:0]];
        else if (loc_hit)
            raw = loc_lines[loc_idx[LOC_IDX_W-1:0]];
        else
            raw = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) fiq <= 1'b0;
        else     fiq <= cfg.en & raw;
    end

    // R8
    fiq_gated_chk: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |=> !fiq);
    // R8
    fiq_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg.sel >= SEL_W'(PER_N + LOC_N)) |=> !fiq);
endmodule

// File: rtl/irqc_summary.sv
module irqc_summary
    import irqc_pkg::*;
(
    input  logic [PER_N-1:0]  per_lines,
    input  logic [LOC_N-1:0]  loc_lines,
    input  logic [PER_N-1:0]  per_en,
    input  logic [LOC_N-1:0]  loc_en,
    output logic [HALF_N-1:0] pend_lo,
    output logic [HALF_N-1:0] pend_hi,
    output logic [DATA_W-1:0] summary,
    output logic              any_pend
);
    logic [PER_N-1:0]    per_pend;
    logic [LOC_N-1:0]    loc_pend;
    logic [MIRROR_N-1:0] mirror;

    assign per_pend = per_lines & per_en;
    assign loc_pend = loc_lines & loc_en;
    assign pend_lo  = per_pend[HALF_N-1:0];
    assign pend_hi  = per_pend[PER_N-1:HALF_N];

    for (genvar g = 0; g < MIRROR_N; g++) begin : g_mirror
        assign mirror[g] = per_pend[mirror_line(g)];
    end

    assign summary  = {{SUM_PAD{1'b0}}, mirror, |pend_hi, |pend_lo, loc_pend};
    assign any_pend = (|per_pend) | (|loc_pend);
endmodule

// File: rtl/banked_irq_ctrl.sv
module banked_irq_ctrl
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PER_N-1:0]  per_lines,
    input  logic [LOC_N-1:0]  loc_lines,
    output logic              irq_out,
    output logic              fiq_out
);
    wr_dec_t           wdec;
    logic              mapped;
    logic [PER_N-1:0]  per_en;
    logic [LOC_N-1:0]  loc_en;
    logic [HALF_N-1:0] pend_lo, pend_hi;
    logic [DATA_W-1:0] summary;
    logic              any_pend;
    fast_cfg_t         fcfg;
    logic [DATA_W-1:0] rd_val;

    // Write decode
    always_comb begin
        wdec = '0;
        if (bus_wr) begin
            case (bus_addr)
                OFF_SET_LO:  wdec.set_per[0] = 1'b1;
                OFF_SET_HI:  wdec.set_per[1] = 1'b1;
                OFF_CLR_LO:  wdec.clr_per[0] = 1'b1;
                OFF_CLR_HI:  wdec.clr_per[1] = 1'b1;
                OFF_SET_LOC: wdec.set_loc    = 1'b1;
                OFF_CLR_LOC: wdec.clr_loc    = 1'b1;
                OFF_FAST:    wdec.fast       = 1'b1;
                default:     wdec = '0;
            endcase
        end
    end

    for (genvar h = 0; h < 2; h++) begin : g_per_half
        irqc_en_bank #(.WIDTH(HALF_N)) u_bank (
            .clk    (clk),
            .rst    (rst),
            .set_we (wdec.set_per[h]),
            .clr_we (wdec.clr_per[h]),
            .bits   (bus_wdata[HALF_N-1:0]),
            .mask   (per_en[h*HALF_N +: HALF_N])
        );
    end

    irqc_en_bank #(.WIDTH(LOC_N)) u_loc_bank (
        .clk    (clk),
        .rst    (rst),
        .set_we (wdec.set_loc),
        .clr_we (wdec.clr_loc),
        .bits   (bus_wdata[LOC_N-1:0]),
        .mask   (loc_en)
    );

    irqc_fast_pick u_fast (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (wdec.fast),
        .cfg_wdata (bus_wdata[7:0]),
        .per_lines (per_lines),
        .loc_lines (loc_lines),
        .cfg       (fcfg),
        .fiq       (fiq_out)
    );

    irqc_summary u_sum (
        .per_lines (per_lines),
        .loc_lines (loc_lines),
        .per_en    (per_en),
        .loc_en    (loc_en),
        .pend_lo   (pend_lo),
        .pend_hi   (pend_hi),
        .summary   (summary),
        .any_pend  (any_pend)
    );

    // Read mux
    always_comb begin
        mapped = 1'b1;
        case (bus_addr)
            OFF_SUMMARY: rd_val = summary;
            OFF_PEND_LO: rd_val = pend_lo;
            OFF_PEND_HI: rd_val = pend_hi;
            OFF_FAST:    rd_val = {{(DATA_W-8){1'b0}}, fcfg};
            OFF_SET_LO:  rd_val = per_en[HALF_N-1:0];
            OFF_SET_HI:  rd_val = per_en[PER_N-1:HALF_N];
            OFF_SET_LOC: rd_val = {{(DATA_W-LOC_N){1'b0}}, loc_en};
            OFF_CLR_LO:  rd_val = ~per_en[HALF_N-1:0];
            OFF_CLR_HI:  rd_val = ~per_en[PER_N-1:HALF_N];
            OFF_CLR_LOC: rd_val = {{(DATA_W-LOC_N){1'b0}}, ~loc_en};
            default: begin
                rd_val = '0;
                mapped = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_val;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_out <= 1'b0;
        else     irq_out <= any_pend;
    end

    // R9
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        any_pend |=> irq_out);
    // R9
    irq_fall_chk: assert property (@(posedge clk) disable iff (rst)
        !any_pend |=> !irq_out);
    // R10
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && !mapped) |=> (bus_rdata == '0));
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_banked_irq_ctrl.sv
module tb_banked_irq_ctrl;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [63:0] per_lines = '0;
    logic [7:0]  loc_lines = '0;
    logic        irq_out, fiq_out;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    banked_irq_ctrl dut (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .per_lines(per_lines), .loc_lines(loc_lines),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, 64'(v), 64'(exp));
    endtask

    task automatic clear_all();
        wr(8'h1C, 32'hFFFF_FFFF);
        wr(8'h20, 32'hFFFF_FFFF);
        wr(8'h24, 32'hFFFF_FFFF);
    endtask

    function automatic int mline(input int i);
        int tbl [11] = '{7, 9, 10, 18, 19, 53, 54, 55, 56, 57, 62};
        return tbl[i];
    endfunction

    task automatic t_reset();
        check("R1 irq", 64'(irq_out), 64'd0);
        check("R1 fiq", 64'(fiq_out), 64'd0);
        rd_chk("R1 set_lo", 8'h10, 32'h0);
        rd_chk("R1 set_hi", 8'h14, 32'h0);
        rd_chk("R1 set_loc", 8'h18, 32'h0);
        rd_chk("R1 fast", 8'h0C, 32'h0);
    endtask

    task automatic t_enables();
        wr(8'h10, 32'h0000_00F0);
        wr(8'h10, 32'h0000_0F00);
        rd_chk("R5 set_lo OR", 8'h10, 32'h0000_0FF0);
        wr(8'h1C, 32'h0000_00F0);
        rd_chk("R6 clr_lo", 8'h10, 32'h0000_0F00);
        rd_chk("R6 clr_lo inverse read", 8'h1C, 32'hFFFF_F0FF);
        wr(8'h18, 32'hFFFF_FF0F);
        rd_chk("R5 set_loc low byte", 8'h18, 32'h0000_000F);
        wr(8'h24, 32'hFFFF_FF03);
        rd_chk("R6 clr_loc", 8'h18, 32'h0000_000C);
        rd_chk("R6 clr_loc inverse read", 8'h24, 32'h0000_00F3);
        wr(8'h14, 32'h0001_0000);
        rd_chk("R5 set_hi", 8'h14, 32'h0001_0000);
        rd_chk("R6 clr_hi inverse read", 8'h20, 32'hFFFE_FFFF);
    endtask

    task automatic t_pending();
        wr(8'h14, 32'hFFFF_0000);
        per_lines = 64'hA5A5_0000_FFFF_1234;
        rd_chk("R2 pend_lo", 8'h04, 32'h0000_0200);
        rd_chk("R2 pend_hi", 8'h08, 32'hA5A5_0000);
        per_lines = 64'h0;
        rd_chk("R2 pend_lo live", 8'h04, 32'h0);
    endtask

    task automatic t_summary();
        clear_all();
        wr(8'h18, 32'h0000_000C);
        loc_lines = 8'h5A;
        rd_chk("R3 local bits", 8'h00, 32'h0000_0008);
        loc_lines = 8'h00;
        wr(8'h10, 32'h0000_0001);
        per_lines = 64'h0000_0001_0000_0001;
        rd_chk("R3 lo flag only", 8'h00, 32'h0000_0100);
        wr(8'h14, 32'h0000_0001);
        rd_chk("R3 both flags", 8'h00, 32'h0000_0300);
        wr(8'h10, 32'hFFFF_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        for (int i = 0; i < 11; i++) begin
            int ln;
            logic [31:0] e;
            ln = mline(i);
            per_lines = 64'd1 << ln;
            e = (32'd1 << (10 + i)) | ((ln < 32) ? 32'h100 : 32'h200);
            rd_chk("R4 mirror", 8'h00, e);
        end
        per_lines = 64'd1 << 8;
        rd_chk("R4 non-mirrored line", 8'h00, 32'h0000_0100);
        per_lines = 64'h0;
    endtask

    task automatic t_irq();
        clear_all();
        per_lines = 64'h0000_0040_0000_0000;
        @(negedge clk); @(negedge clk);
        check("R9 masked line idle", 64'(irq_out), 64'd0);
        wr(8'h14, 32'h0000_0040);
        check("R11 irq one clock late", 64'(irq_out), 64'd0);
        @(negedge clk);
        check("R9 irq asserted", 64'(irq_out), 64'd1);
        per_lines = 64'h0;
        @(negedge clk);
        check("R11 irq after drop", 64'(irq_out), 64'd0);
        clear_all();
        wr(8'h18, 32'h0000_0080);
        loc_lines = 8'h80;
        @(negedge clk);
        check("R9 local irq", 64'(irq_out), 64'd1);
        loc_lines = 8'h00;
        @(negedge clk);
        check("R9 local irq off", 64'(irq_out), 64'd0);
        clear_all();
    endtask

    task automatic t_fast();
        per_lines = 64'd1 << 5;
        wr(8'h0C, 32'h0000_0085);
        @(negedge clk);
        check("R8 fiq raw peripheral", 64'(fiq_out), 64'd1);
        check("R9 irq masked", 64'(irq_out), 64'd0);
        rd_chk("R7 fast readback", 8'h0C, 32'h0000_0085);
        per_lines = 64'h0;
        @(negedge clk);
        check("R8 fiq follows level", 64'(fiq_out), 64'd0);
        loc_lines = 8'h08;
        wr(8'h0C, 32'hFFFF_FFC3);
        rd_chk("R7 fast upper ignored", 8'h0C, 32'h0000_00C3);
        check("R8 fiq local", 64'(fiq_out), 64'd1);
        loc_lines = 8'hFF;
        per_lines = '1;
        wr(8'h0C, 32'h0000_00FF);
        @(negedge clk);
        check("R8 fiq gap selector", 64'(fiq_out), 64'd0);
        wr(8'h0C, 32'h0000_0005);
        @(negedge clk);
        check("R8 fiq disabled", 64'(fiq_out), 64'd0);
        per_lines = '0;
        loc_lines = '0;
    endtask

    task automatic t_unmapped();
        wr(8'h10, 32'h0000_0003);
        wr(8'h28, 32'hFFFF_FFFF);
        wr(8'h04, 32'hFFFF_FFFF);
        wr(8'h00, 32'hFFFF_FFFF);
        rd_chk("R10 writes ignored", 8'h10, 32'h0000_0003);
        rd_chk("R10 fast untouched", 8'h0C, 32'h0000_0005);
        rd_chk("R10 unmapped 0x28", 8'h28, 32'h0);
        rd_chk("R10 unmapped 0x3C", 8'h3C, 32'h0);
        rd_chk("R11 set before hold", 8'h10, 32'h0000_0003);
        @(negedge clk); @(negedge clk);
        check("R11 rdata held", 64'(bus_rdata), 64'h3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enables();
        t_pending();
        t_summary();
        t_irq();
        t_fast();
        t_unmapped();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule